// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Tracker

This block sits beside an SPI shift engine and keeps the bookkeeping that software sees through a read-only 32-bit status word. It counts the bytes in a four-deep receive byte FIFO and a four-deep transmit byte FIFO. It also records receive overflow and transmit underflow as sticky flags. It counts completed bytes since the last transfer start and raises a receive-complete or transmit-complete flag once a programmed number of bytes has gone by. The transfer-mode input picks which of the two complete flags is raised.

A summary interrupt flag collects every enabled interrupt event and drives the interrupt line. Overflow and underflow are masked from the summary while their flush control is on. All sticky flags clear on the clock edge that ends a status-read cycle. If an event arrives in that same cycle, the event wins and its flag stays set. The shifter, the clock divider and the data storage are outside the block. Only their strobes enter it.

Top module: `spi_fifo_status`

## Requirements
- R1: While reset is asserted, the status word reads 0x0000_0000 and irq is low.
- R2: Receive occupancy appears at status[10:8] and transmit occupancy at status[3:1], both as a 3-bit byte count from 0 to 4. A push raises the count by one and a pop lowers it by one. A pop on an empty FIFO changes nothing. A push on a full FIFO with no pop is discarded, so the count stays at 4. A push and a pop in the same cycle leave a non-empty count unchanged.
- R3: status[11] is high exactly while receive occupancy is greater than thr+1, where thr is the 2-bit threshold input giving 1 to 4 bytes. It is not sticky.
- R4: status[7] (receive overflow) is set on the edge after a cycle in which rx_push is high, rx_pop is low and the receive FIFO holds four bytes.
- R5: Transfer start clears a completed-byte counter, and a start in the same cycle as byte_done ignores the byte. Each later byte_done counts, up to four. With xfer_mode=0, the byte that brings the count to thr+1 sets status[6] (receive complete) on the following edge. Bytes after that do not set it again.
- R6: With xfer_mode=1, the same byte count sets status[5] (transmit complete) instead, and status[6] is not set.
- R7: status[4] (transmit underflow) is set on the edge after xfer_start is high while the transmit FIFO is empty. A start with one or more bytes queued does not set it.
- R8: status[0] is set on the edge after any of these events: overflow with rx_flush_en low, underflow with tx_flush_en low, receive complete, or transmit complete. Overflow or underflow with its flush control high sets only its own flag. irq always equals status[0].
- R9: status bits 7, 6, 5, 4 and 0 clear on the edge that ends a cycle with stat_rd high. An event in that same cycle keeps its flag set.
- R10: status bits [31:12] always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| rx_push | input | 1 | Byte written into the receive FIFO |
| rx_pop | input | 1 | Byte taken from the receive FIFO |
| tx_push | input | 1 | Byte written into the transmit FIFO |
| tx_pop | input | 1 | Byte taken from the transmit FIFO |
| xfer_start | input | 1 | Transfer begins |
| byte_done | input | 1 | One byte finished on the serial line |
| xfer_mode | input | 1 | 0: receive-complete events, 1: transmit-complete events |
| rx_flush_en | input | 1 | Masks overflow from the summary interrupt |
| tx_flush_en | input | 1 | Masks underflow from the summary interrupt |
| thr | input | 2 | Bytes per transfer minus one |
| stat_rd | input | 1 | Status word is being read this cycle |
| status | output | 32 | Status word |
| irq | output | 1 | Interrupt line, equal to the summary flag |

## Verification
Every registered result is due on the first rising edge after the cycle that carries its stimulus. This covers occupancy, the four event flags, the summary flag and the clearing done by a read. The excess bit is combinational, but it follows the registered receive count and the present threshold, so it settles in the same cycle. The driver applies each stimulus 2 ns after an edge and queues the word expected after the next edge. The monitor compares it 1 ns after that edge, so every comparison lands exactly one edge behind its stimulus and well away from the edge itself.

// File: rtl/spi_fs_pkg.sv
package spi_fs_pkg;
  localparam int FIFO_DEPTH = 4;
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);
  localparam int THR_W      = 2;
  localparam int STAT_W     = 32;

  // status word layout
  localparam int TXCNT_LSB  = 1;
  localparam int UDF_BIT    = 4;
  localparam int TXC_BIT    = 5;
  localparam int RXC_BIT    = 6;
  localparam int OVF_BIT    = 7;
  localparam int RXCNT_LSB  = 8;
  localparam int EXC_BIT    = 11;
  localparam int SUM_BIT    = 0;

  // sticky flag vector indices
  localparam int N_STICKY   = 5;
  localparam int SK_SUM     = 0;
  localparam int SK_UDF     = 1;
  localparam int SK_TXC     = 2;
  localparam int SK_RXC     = 3;
  localparam int SK_OVF     = 4;
endpackage

// File: rtl/spi_fs_occ.sv
module spi_fs_occ #(
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic          pop_ok, push_ok, cnt_en;
  logic [CW-1:0] count_d;

  always_comb begin
    pop_ok  = pop && (count != '0);
    push_ok = push && ((count != FULL) || pop_ok);
    cnt_en  = push_ok ^ pop_ok;
    count_d = count;
    if (push_ok && !pop_ok) count_d = count + CW'(1);
    else if (pop_ok && !push_ok) count_d = count - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (cnt_en) count <= count_d;
  end

  assert_occ_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL);
  assert_occ_sat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && count == FULL) |=> (count == FULL));
  assert_occ_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && count == '0) |=> (count == '0));
endmodule

// File: rtl/spi_fs_bytecnt.sv
module spi_fs_bytecnt #(
  parameter int LIMIT = 4,
  parameter int TW    = 2,
  parameter int CW    = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          done,
  input  logic [TW-1:0] thr,
  output logic          hit
);
  localparam logic [CW-1:0] CAP = CW'(LIMIT);

  logic [CW-1:0] cnt, cnt_d, target;
  logic          cnt_en, step_ok;

  always_comb begin
    target  = CW'(thr) + CW'(1);
    step_ok = done && !start && (cnt != CAP);
    cnt_en  = start || step_ok;
    cnt_d   = start ? '0 : cnt + CW'(1);
    hit     = step_ok && (cnt_d == target);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CAP);
  assert_start_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt == '0));
endmodule

// File: rtl/spi_fs_sticky.sv
module spi_fs_sticky #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic d, en;
    always_comb begin
      en = set[i] || clr;
      d  = set[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q[i] <= 1'b0;
      else if (en) q[i] <= d;
    end
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> q[i]);
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set[i]) |=> !q[i]);
  end
endmodule

// File: rtl/spi_fifo_status.sv
module spi_fifo_status
  import spi_fs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_push,
  input  logic              rx_pop,
  input  logic              tx_push,
  input  logic              tx_pop,
  input  logic              xfer_start,
  input  logic              byte_done,
  input  logic              xfer_mode,
  input  logic              rx_flush_en,
  input  logic              tx_flush_en,
  input  logic [THR_W-1:0]  thr,
  input  logic              stat_rd,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FIFO_DEPTH);

  logic [CNT_W-1:0]    rx_cnt, tx_cnt, thr_bytes;
  logic                cmp_hit, ovf_evt, udf_evt, rxc_evt, txc_evt, sum_evt, rx_exc;
  logic [N_STICKY-1:0] evt_vec, flags;

  spi_fs_occ #(.DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_rx_occ (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .pop(rx_pop), .count(rx_cnt));

  spi_fs_occ #(.DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_tx_occ (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .pop(tx_pop), .count(tx_cnt));

  spi_fs_bytecnt #(.LIMIT(FIFO_DEPTH), .TW(THR_W), .CW(CNT_W)) u_bytecnt (
    .clk(clk), .rst_n(rst_n), .start(xfer_start), .done(byte_done),
    .thr(thr), .hit(cmp_hit));

  always_comb begin
    ovf_evt   = rx_push && !rx_pop && (rx_cnt == FULL);
    udf_evt   = xfer_start && (tx_cnt == '0);
    rxc_evt   = cmp_hit && !xfer_mode;
    txc_evt   = cmp_hit && xfer_mode;
    sum_evt   = (ovf_evt && !rx_flush_en) || (udf_evt && !tx_flush_en) ||
                rxc_evt || txc_evt;
    thr_bytes = CNT_W'(thr) + CNT_W'(1);
    rx_exc    = rx_cnt > thr_bytes;
    evt_vec           = '0;
    evt_vec[SK_SUM]   = sum_evt;
    evt_vec[SK_UDF]   = udf_evt;
    evt_vec[SK_TXC]   = txc_evt;
    evt_vec[SK_RXC]   = rxc_evt;
    evt_vec[SK_OVF]   = ovf_evt;
  end

  spi_fs_sticky #(.N(N_STICKY)) u_sticky (
    .clk(clk), .rst_n(rst_n), .set(evt_vec), .clr(stat_rd), .q(flags));

  always_comb begin
    status                          = '0;
    status[SUM_BIT]                 = flags[SK_SUM];
    status[TXCNT_LSB +: CNT_W]      = tx_cnt;
    status[UDF_BIT]                 = flags[SK_UDF];
    status[TXC_BIT]                 = flags[SK_TXC];
    status[RXC_BIT]                 = flags[SK_RXC];
    status[OVF_BIT]                 = flags[SK_OVF];
    status[RXCNT_LSB +: CNT_W]      = rx_cnt;
    status[EXC_BIT]                 = rx_exc;
    irq                             = flags[SK_SUM];
  end

  assert_ovf_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && !rx_pop && status[10:8] == 3'd4) |=> status[OVF_BIT]);
  assert_udf_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && status[3:1] == 3'd0) |=> status[UDF_BIT]);
  assert_mode_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_hit |=> (status[TXC_BIT] != status[RXC_BIT]) || $past(stat_rd) == 1'b0);
  assert_irq_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(sum_evt));
  assert_read_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && evt_vec == '0) |=> (status[7:4] == 4'd0 && !status[0]));
  assert_hi_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    status[31:12] == 20'd0);
endmodule

// File: tb/spi_fifo_status_bench.sv
`timescale 1ns/1ps
module spi_fifo_status_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_push = 0, rx_pop = 0, tx_push = 0, tx_pop = 0;
  logic        xfer_start = 0, byte_done = 0, xfer_mode = 0;
  logic        rx_flush_en = 0, tx_flush_en = 0, stat_rd = 0;
  logic [1:0]  thr = 2'd1;
  logic [31:0] status;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  // scenario controls, applied by the driver with each step
  bit       c_mode = 0, c_rxf = 0, c_txf = 0;
  bit [1:0] c_thr = 2'd1;

  // reference model state
  int m_rx = 0, m_tx = 0, m_cnt = 0;
  bit f_sum = 0, f_udf = 0, f_txc = 0, f_rxc = 0, f_ovf = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  spi_fifo_status u_spi_fifo_status (
    .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_pop(rx_pop),
    .tx_push(tx_push), .tx_pop(tx_pop), .xfer_start(xfer_start),
    .byte_done(byte_done), .xfer_mode(xfer_mode), .rx_flush_en(rx_flush_en),
    .tx_flush_en(tx_flush_en), .thr(thr), .stat_rd(stat_rd),
    .status(status), .irq(irq));

  task automatic compare(input logic [31:0] exp_w, input string tag);
    checks++;
    if (status !== exp_w || irq !== exp_w[0]) begin
      fails++;
      $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
               tag, status, irq, exp_w, exp_w[0]);
    end
  endtask

  // monitor: compares 1 ns after each edge with the word queued one edge earlier
  always begin
    @(posedge clk);
    #1;
    if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic step(input bit rxpu, input bit rxpo, input bit txpu, input bit txpo,
                      input bit st, input bit bd, input bit rd, input string tag);
    bit rx_po_ok, rx_pu_ok, tx_po_ok, tx_pu_ok, ovf, udf, hit, rxc, txc, sum;
    int tgt;
    logic [31:0] w;
    @(posedge clk);
    #2;
    rx_push = rxpu; rx_pop = rxpo; tx_push = txpu; tx_pop = txpo;
    xfer_start = st; byte_done = bd; stat_rd = rd;
    xfer_mode = c_mode; rx_flush_en = c_rxf; tx_flush_en = c_txf; thr = c_thr;
    tgt      = int'(c_thr) + 1;
    rx_po_ok = rxpo && m_rx > 0;
    rx_pu_ok = rxpu && (m_rx < 4 || rx_po_ok);
    tx_po_ok = txpo && m_tx > 0;
    tx_pu_ok = txpu && (m_tx < 4 || tx_po_ok);
    ovf      = rxpu && !rxpo && m_rx == 4;
    udf      = st && m_tx == 0;
    hit      = !st && bd && m_cnt < 4 && (m_cnt + 1 == tgt);
    rxc      = hit && !c_mode;
    txc      = hit && c_mode;
    sum      = (ovf && !c_rxf) || (udf && !c_txf) || rxc || txc;
    m_rx     = m_rx + int'(rx_pu_ok) - int'(rx_po_ok);
    m_tx     = m_tx + int'(tx_pu_ok) - int'(tx_po_ok);
    if (st) m_cnt = 0;
    else if (bd && m_cnt < 4) m_cnt++;
    f_ovf = ovf | (f_ovf & !rd);
    f_rxc = rxc | (f_rxc & !rd);
    f_txc = txc | (f_txc & !rd);
    f_udf = udf | (f_udf & !rd);
    f_sum = sum | (f_sum & !rd);
    w        = 32'd0;
    w[11]    = (m_rx > tgt);
    w[10:8]  = 3'(m_rx);
    w[7]     = f_ovf;
    w[6]     = f_rxc;
    w[5]     = f_txc;
    w[4]     = f_udf;
    w[3:1]   = 3'(m_tx);
    w[0]     = f_sum;
    exp_q.push_back(w);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    compare(32'd0, "R1 reset");
    #1 rst_n = 1'b1;

    // R2/R3: fill receive FIFO with a 2-byte threshold
    step(1, 0, 0, 0, 0, 0, 0, "R2 rx push 1");
    step(1, 0, 0, 0, 0, 0, 0, "R2 rx push 2");
    step(1, 0, 0, 0, 0, 0, 0, "R3 excess at 3 bytes");
    step(1, 0, 0, 0, 0, 0, 0, "R2 rx full");
    step(1, 0, 0, 0, 0, 0, 0, "R4 overflow sets flag and summary");
    step(0, 0, 0, 0, 0, 0, 1, "R9 read clears");
    idle("R10 upper bits zero");
    step(1, 1, 0, 0, 0, 0, 0, "R2 push+pop at full");
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 0, 0, 0, "R2 rx pop");
    step(0, 1, 0, 0, 0, 0, 0, "R2 pop on empty");

    // R8: overflow masked by receive flush
    c_rxf = 1;
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, 0, 0, "R2 refill");
    step(1, 0, 0, 0, 0, 0, 0, "R8 masked overflow");
    step(0, 0, 0, 0, 0, 0, 1, "R9 read");
    c_thr = 2'd3;
    idle("R3 no excess at 4 with 4-byte threshold");

    // transmit side
    step(0, 0, 1, 0, 0, 0, 0, "R2 tx push");
    step(0, 0, 1, 0, 0, 0, 0, "R2 tx push");
    step(0, 0, 1, 1, 0, 0, 0, "R2 tx push+pop");
    step(0, 0, 0, 1, 0, 0, 0, "R2 tx pop");
    step(0, 0, 0, 1, 0, 0, 0, "R2 tx pop to empty");
    c_txf = 1;
    step(0, 0, 0, 0, 1, 0, 0, "R7 underflow masked");
    step(0, 0, 0, 0, 0, 0, 1, "R9 read");
    c_txf = 0;
    step(0, 0, 0, 0, 1, 0, 0, "R8 underflow with summary");
    step(0, 0, 0, 0, 0, 0, 1, "R9 read");
    step(0, 0, 1, 0, 0, 0, 0, "R2 tx push");
    step(0, 0, 0, 0, 1, 0, 0, "R7 no underflow with data");

    // R5: receive complete after 3 bytes
    c_mode = 0; c_thr = 2'd2;
    step(0, 0, 0, 0, 1, 0, 1, "R5 start");
    step(0, 0, 0, 0, 0, 1, 0, "R5 byte 1");
    step(0, 0, 0, 0, 0, 1, 0, "R5 byte 2");
    step(0, 0, 0, 0, 0, 1, 0, "R5 byte 3 completes");
    step(0, 0, 0, 0, 0, 0, 1, "R9 read");
    step(0, 0, 0, 0, 0, 1, 0, "R5 no refire");
    step(0, 0, 0, 0, 1, 1, 0, "R5 start ignores same-cycle byte");
    step(0, 0, 0, 0, 0, 1, 0, "R5 byte 1 after start");

    // R6: transmit complete after 1 byte; read collides with event
    c_mode = 1; c_thr = 2'd0;
    step(0, 0, 0, 0, 1, 0, 1, "R6 start");
    step(0, 0, 0, 0, 0, 1, 0, "R6 tx complete");
    step(0, 0, 0, 0, 1, 0, 1, "R9 read+start");
    step(0, 0, 0, 0, 0, 1, 1, "R9 event beats read");
    step(0, 0, 0, 0, 0, 0, 1, "R9 final read");
    idle("R9 cleared");

    @(posedge clk);
    #2;
    rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0;
    xfer_start = 0; byte_done = 0; stat_rd = 0;
    @(posedge clk);
    #3;
    finish_run();
  end
endmodule